// File: doc/BRIEF.md
# AES3 Subframe Parity Monitor

This block watches four AES3 stereo-pair lines, one input wire per pair. Each line carries a bi-phase-mark stream sampled by a clock running at 16 times the bit rate, so every bit cell lasts 16 clocks and every half cell lasts 8. For each pair the block measures the time between line transitions and turns those intervals into bits. It finds the three sync preambles by their coding violation, which is a pulse three half cells long. It then assembles the 32 time slots of each subframe.

The audio sample, auxiliary nibble and V/U/C/P flags of each completed subframe are put out on one valid/ready stream per pair. A subframe with bad parity latches a sticky error flag for its own pair. A host reads these flags through two registers. Reading the snapshot register (address 2) copies the live flags into a holding register. Reading the flag register (address 1) returns the held copy and clears what it reported.

Back-pressure rule: a subframe is offered with `sf_valid_o` high and stays unchanged until `sf_ready_i` is seen high at a clock edge. The line cannot be paused. If a new subframe completes while the old one is still unaccepted, the new one replaces it and the old one is lost. Parity checking and error flags do not depend on `sf_ready_i`.

Top module: `aes_parity_mon`

## Requirements
- R1: Each subframe has 32 slots. Slots 0-3 are the preamble. In bi-phase-mark coding every bit cell starts with a transition, and a 1 has an extra transition in mid-cell. `sf_vucp_o` carries slot 28 (validity) in bit 3, slot 29 (user) in bit 2, slot 30 (channel status) in bit 1 and slot 31 (parity) in bit 0.
- R2: With `mode_i`=00 (24-bit words), `sf_sample_o` holds slots 4-27 with slot 4 as bit 0, and `sf_aux_o` is 0.
- R3: With `mode_i`=01 (20-bit words), `sf_aux_o` holds slots 4-7 with slot 4 as bit 0. `sf_sample_o` holds slots 8-27 with slot 8 as bit 0, and its upper 4 bits are zero.
- R4: With `mode_i`=10 (16-bit words), `sf_aux_o` holds slots 4-7. `sf_sample_o` holds slots 12-27 with slot 12 as bit 0 and its upper 8 bits zero, so slots 8-11 have no effect. `mode_i`=11 behaves as 00.
- R5: `sf_pre_o` gives the preamble that opened the subframe. Runs of 3,3,1,1 half cells give 0 (channel A). Runs of 3,2,1,2 give 1 (channel B). Runs of 3,1,1,3 give 2 (block start, channel A).
- R6: `sf_perr_o` is the XOR of slots 4-31, so even parity is expected. A subframe with this bit set sets the sticky flag of its own pair only. Bit i of the flags belongs to line i.
- R7: A read at address 2 copies the sticky flags into the holding register. On the next cycle `rd_data_o` shows the sticky flags as they were before the read.
- R8: A read at address 1 puts the holding register on `rd_data_o` on the next cycle. It then clears the holding register and every sticky flag it reported. If no address-2 read came first, the read returns the stale (cleared) copy and leaves the sticky flags untouched.
- R9: A parity error that arrives in the same cycle as an address-1 read remains set in the sticky flags.
- R10: An unaccepted subframe stays valid with stable fields while `sf_ready_i` is low. A newer subframe overwrites it. Valid drops after a handshake.
- R11: After reset every valid output, flag and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16x the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Word-length mode |
| line_i | input | NPAIR | Bi-phase-mark line per stereo pair |
| sf_ready_i | input | NPAIR | Consumer ready per pair |
| sf_valid_o | output | NPAIR | Subframe offered per pair |
| sf_sample_o | output | NPAIR*24 | Audio sample per pair, right-aligned |
| sf_aux_o | output | NPAIR*4 | Auxiliary nibble per pair |
| sf_vucp_o | output | NPAIR*4 | V,U,C,P per pair |
| sf_pre_o | output | NPAIR*2 | Preamble code per pair |
| sf_perr_o | output | NPAIR | Parity failure of the offered subframe |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 2 | Host read address (1 flags, 2 snapshot) |
| rd_data_o | output | NPAIR | Host read data, one cycle after the strobe |

## Verification
The case hardest to reach from the ports is a parity error landing in exactly the cycle of an address-1 read. The error appears a few register stages after the last line transition, so its cycle is not visible from outside. The bench holds the address-1 read asserted on every cycle while a bad subframe streams in, so the error is certain to coincide with a read. It then checks through a normal snapshot-then-read pair that the flag survived. A second scenario lands a new error between the snapshot and the flag read and checks that the new error waits for the next snapshot.

// File: rtl/aes_mon_pkg.sv
package aes_mon_pkg;
  localparam int SLOTS    = 32;
  localparam int SAMPLE_W = 24;
  localparam int AUX_W    = 4;

  localparam logic [1:0] ADDR_FLAGS = 2'd1;
  localparam logic [1:0] ADDR_SNAP  = 2'd2;

  typedef enum logic [1:0] {WL_24 = 2'b00, WL_20 = 2'b01, WL_16 = 2'b10} wlen_e;
  typedef enum logic [1:0] {PRE_X = 2'd0, PRE_Y = 2'd1, PRE_Z = 2'd2} pre_e;
  typedef enum logic [1:0] {ST_HUNT, ST_PRE, ST_DATA} rx_st_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] sample;
    logic [AUX_W-1:0]    aux;
    logic [3:0]          vucp;
    pre_e                pre;
    logic                perr;
  } sf_fields_t;
endpackage

// File: rtl/aes_bmc_rx.sv
module aes_bmc_rx
  import aes_mon_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic             sf_strobe_o,
  output logic [SLOTS-1:0] sf_word_o,
  output pre_e             sf_pre_o
);
  localparam int HALF    = OSR / 2;
  localparam int RUN_MAX = 4 * HALF;
  localparam int CW      = $clog2(RUN_MAX + 1);
  localparam logic [CW-1:0] TH_MIN = CW'(HALF / 2);
  localparam logic [CW-1:0] TH_1   = CW'(HALF + HALF / 2);
  localparam logic [CW-1:0] TH_2   = CW'(2 * HALF + HALF / 2);
  localparam logic [CW-1:0] TH_3   = CW'(3 * HALF + HALF / 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(RUN_MAX);

  logic [2:0]    sync_q;
  logic          trans;
  logic [CW-1:0] run_cnt;
  logic [1:0]    hc;
  rx_st_e        st;
  logic [3:0]    pre_hc, pre_sum;
  logic [1:0]    pre_idx;
  pre_e          pre_kind;
  logic          half_pend;
  logic [4:0]    slot;
  logic [SLOTS-1:0] word;
  logic          strobe;
  logic          bit_evt, bit_val;

  assign trans = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      run_cnt <= '0;
    end else begin
      sync_q <= {sync_q[1:0], line_i};
      if (trans) run_cnt <= CW'(1);
      else if (run_cnt != CNT_SAT) run_cnt <= run_cnt + CW'(1);
    end
  end

  // Interval length in half cells; 0 marks an out-of-range interval.
  always_comb begin
    if (run_cnt < TH_MIN)    hc = 2'd0;
    else if (run_cnt < TH_1) hc = 2'd1;
    else if (run_cnt < TH_2) hc = 2'd2;
    else if (run_cnt < TH_3) hc = 2'd3;
    else                     hc = 2'd0;
  end

  assign pre_sum = pre_hc + {2'b00, hc};

  always_comb begin
    bit_evt = 1'b0;
    bit_val = 1'b0;
    if (trans && st == ST_DATA) begin
      if (hc == 2'd2 && !half_pend) begin
        bit_evt = 1'b1;
      end else if (hc == 2'd1 && half_pend) begin
        bit_evt = 1'b1;
        bit_val = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HUNT;
      pre_hc    <= '0;
      pre_idx   <= '0;
      pre_kind  <= PRE_X;
      half_pend <= 1'b0;
      slot      <= '0;
      word      <= '0;
      strobe    <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (trans) begin
        if (st == ST_PRE) begin
          if (hc == 2'd0) st <= ST_HUNT;
          else begin
            if (pre_idx == 2'd1)
              pre_kind <= (hc == 2'd3) ? PRE_X : (hc == 2'd2) ? PRE_Y : PRE_Z;
            pre_idx <= pre_idx + 2'd1;
            pre_hc  <= pre_sum;
            if (pre_sum == 4'd8) begin
              st        <= ST_DATA;
              slot      <= 5'd4;
              half_pend <= 1'b0;
            end else if (pre_sum > 4'd8 || pre_idx == 2'd3) begin
              st <= ST_HUNT;
            end
          end
        end else if (hc == 2'd3) begin
          st      <= ST_PRE;
          pre_hc  <= 4'd3;
          pre_idx <= 2'd1;
        end else if (st == ST_DATA) begin
          if (bit_evt) begin
            word[slot] <= bit_val;
            half_pend  <= 1'b0;
            if (slot == 5'd31) begin
              strobe <= 1'b1;
              st     <= ST_HUNT;
            end else begin
              slot <= slot + 5'd1;
            end
          end else if (hc == 2'd1) begin
            half_pend <= 1'b1;
          end else begin
            st <= ST_HUNT;
          end
        end
      end
    end
  end

  assign sf_strobe_o = strobe;
  assign sf_word_o   = word;
  assign sf_pre_o    = pre_kind;

  // R1
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_strobe_o |=> !sf_strobe_o);

  // R1
  data_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> (slot >= 5'd4));
endmodule

// File: rtl/aes_sf_unpack.sv
module aes_sf_unpack
  import aes_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             strobe_i,
  input  logic [SLOTS-1:0] word_i,
  input  pre_e             pre_i,
  input  logic             perr_i,
  input  logic             ready_i,
  output logic             valid_o,
  output sf_fields_t       fields_o
);
  sf_fields_t ext;

  always_comb begin
    ext      = '0;
    ext.vucp = {word_i[28], word_i[29], word_i[30], word_i[31]};
    ext.pre  = pre_i;
    ext.perr = perr_i;
    case (wlen_e'(mode_i))
      WL_20: begin
        ext.aux    = word_i[7:4];
        ext.sample = {4'b0, word_i[27:8]};
      end
      WL_16: begin
        ext.aux    = word_i[7:4];
        ext.sample = {8'b0, word_i[27:12]};
      end
      default: ext.sample = word_i[27:4];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      fields_o <= '0;
    end else if (strobe_i) begin
      valid_o  <= 1'b1;
      fields_o <= ext;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i && !strobe_i |=> valid_o && $stable(fields_o));

  // R4
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && (mode_i == WL_16) |=> (fields_o.sample[23:16] == 8'h00));
endmodule

// File: rtl/aes_err_regs.sv
module aes_err_regs
  import aes_mon_pkg::*;
#(
  parameter int NPAIR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] err_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_addr_i,
  output logic [NPAIR-1:0] rd_data_o
);
  logic [NPAIR-1:0] sticky_q, snap_q;
  logic rd_flags, rd_snap;

  assign rd_flags = rd_en_i && (rd_addr_i == ADDR_FLAGS);
  assign rd_snap  = rd_en_i && (rd_addr_i == ADDR_SNAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q  <= '0;
      snap_q    <= '0;
      rd_data_o <= '0;
    end else begin
      if (rd_flags) sticky_q <= (sticky_q & ~snap_q) | err_i;
      else          sticky_q <= sticky_q | err_i;
      if (rd_snap)       snap_q <= sticky_q;
      else if (rd_flags) snap_q <= '0;
      if (rd_flags)      rd_data_o <= snap_q;
      else if (rd_snap)  rd_data_o <= sticky_q;
      else               rd_data_o <= '0;
    end
  end

  for (genvar gi = 0; gi < NPAIR; gi++) begin : g_chk
    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_i[gi] |=> sticky_q[gi]);
    // R9
    rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_flags && err_i[gi] |=> sticky_q[gi] && !snap_q[gi]);
    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_flags && snap_q[gi] && !err_i[gi] |=> !sticky_q[gi]);
  end
endmodule

// File: rtl/aes_parity_mon.sv
module aes_parity_mon
  import aes_mon_pkg::*;
#(
  parameter int NPAIR = 4,
  parameter int OSR   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode_i,
  input  logic [NPAIR-1:0]          line_i,
  input  logic [NPAIR-1:0]          sf_ready_i,
  output logic [NPAIR-1:0]          sf_valid_o,
  output logic [NPAIR*SAMPLE_W-1:0] sf_sample_o,
  output logic [NPAIR*AUX_W-1:0]    sf_aux_o,
  output logic [NPAIR*4-1:0]        sf_vucp_o,
  output logic [NPAIR*2-1:0]        sf_pre_o,
  output logic [NPAIR-1:0]          sf_perr_o,
  input  logic                      rd_en_i,
  input  logic [1:0]                rd_addr_i,
  output logic [NPAIR-1:0]          rd_data_o
);
  logic [NPAIR-1:0] err_pulse;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic             strobe;
    logic [SLOTS-1:0] word;
    pre_e             pre;
    logic             par;
    sf_fields_t       fields;

    aes_bmc_rx #(.OSR(OSR)) u_rx (
      .clk(clk), .rst_n(rst_n), .line_i(line_i[p]),
      .sf_strobe_o(strobe), .sf_word_o(word), .sf_pre_o(pre)
    );

    assign par          = ^word[SLOTS-1:4];
    assign err_pulse[p] = strobe & par;

    aes_sf_unpack u_unpack (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .strobe_i(strobe), .word_i(word), .pre_i(pre), .perr_i(par),
      .ready_i(sf_ready_i[p]), .valid_o(sf_valid_o[p]), .fields_o(fields)
    );

    assign sf_sample_o[p*SAMPLE_W +: SAMPLE_W] = fields.sample;
    assign sf_aux_o[p*AUX_W +: AUX_W]          = fields.aux;
    assign sf_vucp_o[p*4 +: 4]                 = fields.vucp;
    assign sf_pre_o[p*2 +: 2]                  = fields.pre;
    assign sf_perr_o[p]                        = fields.perr;
  end

  aes_err_regs #(.NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst_n(rst_n), .err_i(err_pulse),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/tb_aes_parity_mon.sv
module tb_aes_parity_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int OSR  = 16;
  localparam int HALF = OSR / 2;
  localparam int MAXSF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_r = 2'b00;
  logic [NP-1:0] line = '0;
  logic [NP-1:0] ready = '1;
  logic [NP-1:0] sf_valid_o, sf_perr_o, rd_data_o;
  logic [NP*24-1:0] sf_sample_o;
  logic [NP*4-1:0] sf_aux_o, sf_vucp_o;
  logic [NP*2-1:0] sf_pre_o;
  logic rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;

  int tests = 0;
  int fails = 0;
  logic [NP-1:0] lv = '0;
  logic [31:0] tx [NP][MAXSF];
  int unsigned seed = 32'h1234_5678;

  typedef struct {
    logic [23:0] s;
    logic [3:0]  a;
    logic [3:0]  v;
    logic [1:0]  pr;
    logic        pe;
  } exp_t;
  exp_t expq [NP][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_parity_mon #(.NPAIR(NP), .OSR(OSR)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_r), .line_i(line),
    .sf_ready_i(ready), .sf_valid_o(sf_valid_o), .sf_sample_o(sf_sample_o),
    .sf_aux_o(sf_aux_o), .sf_vucp_o(sf_vucp_o), .sf_pre_o(sf_pre_o),
    .sf_perr_o(sf_perr_o), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pre_of(input int k);
    if (k == 0) return 2'd2;
    return (k % 2 == 1) ? 2'd1 : 2'd0;
  endfunction

  // Level toggles at the start of half cell h of subframe k
  function automatic logic tog(input int k, input int h, input logic [31:0] w);
    logic [1:0] pr;
    pr = pre_of(k);
    if (h < 8) begin
      if (h == 0 || h == 3) return 1'b1;
      case (pr)
        2'd0:    return (h == 6 || h == 7);
        2'd1:    return (h == 5 || h == 6);
        default: return (h == 4 || h == 5);
      endcase
    end
    if (h % 2 == 0) return 1'b1;
    return w[h/2];
  endfunction

  function automatic exp_t exp_of(input logic [31:0] w, input int k, input logic [1:0] m);
    exp_t e;
    int lo, wid;
    e.s = '0; e.a = '0;
    if (m == 2'b01)      begin lo = 8;  wid = 20; end
    else if (m == 2'b10) begin lo = 12; wid = 16; end
    else                 begin lo = 4;  wid = 24; end
    for (int i = 0; i < wid; i++) e.s[i] = w[lo+i];
    if (m == 2'b01 || m == 2'b10)
      for (int i = 0; i < 4; i++) e.a[i] = w[4+i];
    e.v  = {w[28], w[29], w[30], w[31]};
    e.pr = pre_of(k);
    e.pe = 1'b0;
    for (int i = 4; i < 32; i++) e.pe = e.pe ^ w[i];
    return e;
  endfunction

  // bad_mask: pairs that get one bad subframe at index bad_k; push_mask: pairs queued
  task automatic prep(input int nsf, input logic [NP-1:0] bad_mask, input int bad_k,
                      input logic [NP-1:0] push_mask);
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < nsf; k++) begin
        logic [31:0] w;
        seed = seed * 32'd1103515245 + 32'd12345;
        w = {1'b0, seed[30:4], 4'b0000};
        w[31] = (^w[30:4]) ^ (bad_mask[p] && k == bad_k);
        tx[p][k] = w;
        if (push_mask[p]) expq[p].push_back(exp_of(w, k, mode_r));
      end
  endtask

  task automatic drive_phase(input int nsf);
    for (int k = 0; k < nsf; k++)
      for (int h = 0; h < 64; h++) begin
        for (int p = 0; p < NP; p++) if (tog(k, h, tx[p][k])) lv[p] = ~lv[p];
        @(posedge clk); #1 line = lv;
        repeat (HALF-1) @(posedge clk);
      end
    lv = ~lv;
    @(posedge clk); #1 line = lv;
    repeat (200) @(posedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, input logic [NP-1:0] exp, input string req);
    @(posedge clk); #1 rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1 rd_en = 1'b0; rd_addr = 2'd0;
    @(negedge clk);
    chk(req, 64'(rd_data_o), 64'(exp));
  endtask

  // Stream monitor: every clock, each accepted beat against the model queue
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (sf_valid_o[p] && ready[p]) begin
          if (expq[p].size() == 0) begin
            chk("R10 unexpected beat", 64'(1), 64'(0));
          end else begin
            exp_t e;
            e = expq[p].pop_front();
            chk("R1,R2,R3,R4,R5,R6 beat",
                {27'd0, sf_sample_o[p*24 +: 24], sf_aux_o[p*4 +: 4],
                 sf_vucp_o[p*4 +: 4], sf_pre_o[p*2 +: 2], sf_perr_o[p]},
                {27'd0, e.s, e.a, e.v, e.pr, e.pe});
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid after reset", 64'(sf_valid_o), 64'(0));
    chk("R11 rd_data after reset", 64'(rd_data_o), 64'(0));
    host_read(2'd2, 4'b0000, "R11 flags after reset");

    // 24-bit mode, pair 1 bad on subframe 1
    mode_r = 2'b00;
    prep(3, 4'b0010, 1, 4'b1111);
    drive_phase(3);
    host_read(2'd1, 4'b0000, "R8 stale copy without snapshot");
    host_read(2'd2, 4'b0010, "R7 R6 snapshot shows pair 1");
    host_read(2'd1, 4'b0010, "R8 flag read returns snapshot");
    host_read(2'd2, 4'b0000, "R8 flags cleared by read");
    host_read(2'd1, 4'b0000, "R8 holding register cleared");

    // 20-bit mode, pairs 2 and 3 bad
    mode_r = 2'b01;
    prep(4, 4'b1100, 2, 4'b1111);
    drive_phase(4);
    host_read(2'd2, 4'b1100, "R7 R3 snapshot pairs 2,3");
    host_read(2'd1, 4'b1100, "R8 read pairs 2,3");

    // 16-bit mode and the reserved mode code
    mode_r = 2'b10;
    prep(3, 4'b0000, 0, 4'b1111);
    drive_phase(3);
    mode_r = 2'b11;
    prep(2, 4'b0000, 0, 4'b1111);
    drive_phase(2);
    host_read(2'd2, 4'b0000, "R4 R6 no error in clean stream");
    host_read(2'd1, 4'b0000, "R8 clean read");

    // back-pressure on pair 0
    mode_r = 2'b00;
    @(posedge clk); #1 ready[0] = 1'b0;
    prep(2, 4'b0000, 0, 4'b1110);
    drive_phase(2);
    begin
      exp_t e2;
      e2 = exp_of(tx[0][1], 1, 2'b00);
      @(negedge clk);
      chk("R10 held valid", 64'(sf_valid_o[0]), 64'(1));
      chk("R10 newer subframe overwrote", 64'(sf_sample_o[23:0]), 64'(e2.s));
      repeat (5) @(negedge clk);
      chk("R10 still held", 64'({sf_valid_o[0], sf_sample_o[23:0]}), 64'({1'b1, e2.s}));
      expq[0].push_back(e2);
      @(posedge clk); #1 ready[0] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 valid drops after handshake", 64'(sf_valid_o[0]), 64'(0));
      chk("R10 exactly one beat delivered", 64'(expq[0].size()), 64'(0));
    end

    // R9: flag read held on every cycle while pair 3 fails parity
    prep(2, 4'b1000, 1, 4'b1111);
    @(posedge clk); #1 rd_en = 1'b1; rd_addr = 2'd1;
    drive_phase(2);
    @(posedge clk); #1 rd_en = 1'b0; rd_addr = 2'd0;
    host_read(2'd2, 4'b1000, "R9 error kept during flag read");
    host_read(2'd1, 4'b1000, "R9 error reported");

    // error between snapshot and flag read waits for next snapshot
    prep(1, 4'b0001, 0, 4'b1111);
    drive_phase(1);
    host_read(2'd2, 4'b0001, "R7 snapshot pair 0");
    prep(1, 4'b0010, 0, 4'b1111);
    drive_phase(1);
    host_read(2'd1, 4'b0001, "R8 read excludes later error");
    host_read(2'd2, 4'b0010, "R8 later error still sticky");
    host_read(2'd1, 4'b0010, "R8 later error reported");

    for (int p = 0; p < NP; p++)
      chk("R1 all subframes delivered", 64'(expq[p].size()), 64'(0));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule